// File: doc/BRIEF.md
# Memory Error Statistics Counter Unit

This unit sits behind a memory ECC checker and keeps statistics on the events the checker reports. Each event is either correctable (CE) or uncorrectable (UE). It carries a flag that says whether its location is known, a chip-select row index and a channel index. The unit keeps controller-wide totals for each type, plus per-row totals. Inside each row it keeps a counter per type for each channel. Events whose location is unknown, or whose row index lies beyond the configured row count, go to dedicated no-location counters. The unit also counts whole seconds since the last clear, so software can turn the counts into error rates.

A single clear strobe zeroes every counter, restarts the seconds timer and releases a pending panic request. When panic-on-UE is enabled, an uncorrectable event raises a sticky panic request and leaves the UE counters untouched. Two log enables gate one-cycle log-request pulses toward the software logging path. They never affect the counting. All values are read through a registered read port.

A small control state machine holds the panic condition and has two states:
- `ST_RUN`: normal operation. Transition `RUN_TO_PANIC` is taken when an accepted UE event arrives while panic-on-UE is set.
- `ST_PANIC`: `panic_req` is high. Transition `PANIC_TO_RUN` is taken on the clear strobe.

In both states the machine registers the log-request outputs.

Top module: `mes_stats_top`

## Requirements
- R1: After reset every counter and the seconds value read as 0, and `panic_req`, `log_ce_req` and `log_ue_req` are low.
- R2: Each accepted CE event adds 1 to the controller CE total at address 0. Each accepted and counted UE event adds 1 to the controller UE total at address 1. This holds whether or not the event location is known.
- R3: An accepted event with `ev_loc_valid`=1 and `ev_row` < ROWS adds 1 to two counters of its own type: the one for that row, and the one for that row and channel. No other row or channel counter changes.
- R4: An event with `ev_loc_valid`=0, or with `ev_row` >= ROWS, adds 1 to the CE no-location counter (address 2) or the UE no-location counter (address 3), according to its type. It changes no row or channel counter.
- R5: A cycle with `clr_strobe`=1 has these effects, whatever else is driven in that cycle:
  - every counter, the seconds value and the prescaler are zeroed;
  - `panic_req` is released;
  - an event in the same cycle is dropped, so it is not counted, logged or used to raise a panic.
- R6: While `panic_on_ue`=1, an accepted UE event sets `panic_req` from the next cycle until the next clear, and changes no UE counter. CE events are still counted.
- R7: The cycle after an accepted CE event, `log_ce_req` pulses high for one cycle if `log_ce_en` was 1. The cycle after an accepted UE event, `log_ue_req` pulses high for one cycle if `log_ue_en` was 1. Counting is the same with the enables set or cleared.
- R8: Every counter saturates at 2^CNT_W-1 and never wraps.
- R9: The seconds value (address 4) rises by 1 every CYCLES_PER_SEC cycles after reset or clear, and saturates at 2^SEC_W-1.
- R10: `rd_data` holds the register selected by `rd_addr` in the cycle before. The read map is as follows:
  - addresses 0 to 4 are the global registers;
  - row r starts at 8+8r, with the row CE count at +0 and the row UE count at +1;
  - channel c of that row has its CE count at +2+2c and its UE count at +3+2c;
  - every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_strobe | input | 1 | Clears all counters, the timer and the panic request |
| panic_on_ue | input | 1 | UE events raise a panic and are not counted |
| log_ce_en | input | 1 | Enables CE log-request pulses |
| log_ue_en | input | 1 | Enables UE log-request pulses |
| ev_valid | input | 1 | An error event is present this cycle |
| ev_is_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_loc_valid | input | 1 | Row and channel fields are meaningful |
| ev_row | input | $clog2(ROWS)+1 | Chip-select row index |
| ev_chan | input | $clog2(NCH) | Channel index |
| rd_addr | input | $clog2(8*(ROWS+1)) | Register read address |
| rd_data | output | RD_W | Registered read data |
| panic_req | output | 1 | Sticky panic request |
| log_ce_req | output | 1 | One-cycle CE log request |
| log_ue_req | output | 1 | One-cycle UE log request |

## Verification
A vector table mixes several kinds of events, with logging both on and off:
- located CE and UE events across different rows and both channels, which separate row indexing from channel indexing;
- no-location events and events with an out-of-range row, which show that the no-location path is taken instead of a row;
- repeated hits on one row and channel, which drive the counters into saturation.

A full read sweep then compares every address against a model, which catches cross-talk between counters and any decode of unmapped addresses. Directed sequences cover the remaining cases. One puts a clear and an event in the same cycle. One sends UE events with panic enabled, to show that counting stops while CE counting and logging continue. One lets the timer run into saturation.

// File: rtl/mes_pkg.sv
package mes_pkg;

    // Control state: normal counting or panic requested.
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_PANIC = 1'b1
    } mes_state_e;

    // Increment requests for the controller-wide counters.
    typedef struct packed {
        logic ce_tot;
        logic ue_tot;
        logic ce_ni;
        logic ue_ni;
    } mes_glob_inc_t;

    // Field offsets inside the global block of the read map.
    localparam int FLD_CE_TOT = 0;
    localparam int FLD_UE_TOT = 1;
    localparam int FLD_CE_NI  = 2;
    localparam int FLD_UE_NI  = 3;
    localparam int FLD_SEC    = 4;

endpackage

// File: rtl/mes_sat_counter.sv
module mes_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != {CNT_W{1'b1}})) begin
            q <= q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mes_sec_timer.sv
module mes_sec_timer #(
    parameter int CPS   = 100_000_000,
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [SEC_W-1:0] sec
);

    localparam int PW = (CPS > 2) ? $clog2(CPS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CPS - 1);

    logic [PW-1:0] pre_q;
    logic          tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sec   <= '0;
        end else if (clr) begin
            pre_q <= '0;
            sec   <= '0;
        end else begin
            if (tick) begin
                pre_q <= '0;
                if (sec != {SEC_W{1'b1}}) begin
                    sec <= sec + SEC_W'(1);
                end
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/mes_evt_decode.sv
module mes_evt_decode
    import mes_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int NCH  = 2,
    localparam int RIW = $clog2(ROWS) + 1,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                 ev_valid,
    input  logic                 ev_is_ue,
    input  logic                 ev_loc_valid,
    input  logic [RIW-1:0]       ev_row,
    input  logic [CHW-1:0]       ev_chan,
    input  logic                 clr,
    input  logic                 panic_on_ue,
    output mes_glob_inc_t        glob_inc,
    output logic [ROWS-1:0]      row_ce_inc,
    output logic [ROWS-1:0]      row_ue_inc,
    output logic [ROWS*NCH-1:0]  ch_ce_inc,
    output logic [ROWS*NCH-1:0]  ch_ue_inc,
    output logic                 ce_take,
    output logic                 ue_take
);

    localparam logic [RIW-1:0] ROWS_L = RIW'(ROWS);

    logic take;
    logic ue_cnt;
    logic located;

    always_comb begin
        take     = ev_valid & ~clr;
        ce_take  = take & ~ev_is_ue;
        ue_take  = take & ev_is_ue;
        ue_cnt   = ue_take & ~panic_on_ue;
        located  = ev_loc_valid & (ev_row < ROWS_L);

        glob_inc.ce_tot = ce_take;
        glob_inc.ue_tot = ue_cnt;
        glob_inc.ce_ni  = ce_take & ~located;
        glob_inc.ue_ni  = ue_cnt & ~located;

        for (int r = 0; r < ROWS; r++) begin
            row_ce_inc[r] = ce_take & located & (ev_row == RIW'(r));
            row_ue_inc[r] = ue_cnt & located & (ev_row == RIW'(r));
            for (int c = 0; c < NCH; c++) begin
                ch_ce_inc[r*NCH+c] = row_ce_inc[r] & (ev_chan == CHW'(c));
                ch_ue_inc[r*NCH+c] = row_ue_inc[r] & (ev_chan == CHW'(c));
            end
        end
    end

endmodule

// File: rtl/mes_ctl_fsm.sv
module mes_ctl_fsm
    import mes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ce_take,
    input  logic ue_take,
    input  logic panic_on_ue,
    input  logic log_ce_en,
    input  logic log_ue_en,
    output logic panic_req,
    output logic log_ce_req,
    output logic log_ue_req
);

    mes_state_e state_q;
    mes_state_e state_d;

    // Next-state logic: RUN_TO_PANIC and PANIC_TO_RUN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ue_take && panic_on_ue) begin
                    state_d = ST_PANIC;
                end
            end
            ST_PANIC: begin
                if (clr) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_ce_req <= 1'b0;
            log_ue_req <= 1'b0;
        end else begin
            log_ce_req <= ce_take & log_ce_en;
            log_ue_req <= ue_take & log_ue_en;
        end
    end

    assign panic_req = (state_q == ST_PANIC);

endmodule

// File: rtl/mes_stats_top.sv
module mes_stats_top
    import mes_pkg::*;
#(
    parameter int ROWS           = 8,
    parameter int NCH            = 2,
    parameter int CNT_W          = 32,
    parameter int SEC_W          = 32,
    parameter int RD_W           = 32,
    parameter int CYCLES_PER_SEC = 100_000_000,
    localparam int RIW    = $clog2(ROWS) + 1,
    localparam int CHW    = $clog2(NCH),
    localparam int STRIDE = 2 ** $clog2(2 + 2 * NCH),
    localparam int SH     = $clog2(STRIDE),
    localparam int AW     = $clog2(STRIDE * (ROWS + 1)),
    localparam int RXW    = AW - SH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_strobe,
    input  logic            panic_on_ue,
    input  logic            log_ce_en,
    input  logic            log_ue_en,
    input  logic            ev_valid,
    input  logic            ev_is_ue,
    input  logic            ev_loc_valid,
    input  logic [RIW-1:0]  ev_row,
    input  logic [CHW-1:0]  ev_chan,
    input  logic [AW-1:0]   rd_addr,
    output logic [RD_W-1:0] rd_data,
    output logic            panic_req,
    output logic            log_ce_req,
    output logic            log_ue_req
);

    mes_glob_inc_t          glob_inc;
    logic [ROWS-1:0]        row_ce_inc;
    logic [ROWS-1:0]        row_ue_inc;
    logic [ROWS*NCH-1:0]    ch_ce_inc;
    logic [ROWS*NCH-1:0]    ch_ue_inc;
    logic                   ce_take;
    logic                   ue_take;

    logic [CNT_W-1:0]       ce_tot_q;
    logic [CNT_W-1:0]       ue_tot_q;
    logic [CNT_W-1:0]       ce_ni_q;
    logic [CNT_W-1:0]       ue_ni_q;
    logic [SEC_W-1:0]       sec_q;
    logic [CNT_W-1:0]       row_ce_q [ROWS];
    logic [CNT_W-1:0]       row_ue_q [ROWS];
    logic [CNT_W-1:0]       ch_ce_q  [ROWS*NCH];
    logic [CNT_W-1:0]       ch_ue_q  [ROWS*NCH];
    logic [RD_W-1:0]        rd_mux;

    mes_evt_decode #(.ROWS(ROWS), .NCH(NCH)) u_dec (
        .ev_valid     (ev_valid),
        .ev_is_ue     (ev_is_ue),
        .ev_loc_valid (ev_loc_valid),
        .ev_row       (ev_row),
        .ev_chan      (ev_chan),
        .clr          (clr_strobe),
        .panic_on_ue  (panic_on_ue),
        .glob_inc     (glob_inc),
        .row_ce_inc   (row_ce_inc),
        .row_ue_inc   (row_ue_inc),
        .ch_ce_inc    (ch_ce_inc),
        .ch_ue_inc    (ch_ue_inc),
        .ce_take      (ce_take),
        .ue_take      (ue_take)
    );

    mes_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr_strobe),
        .ce_take     (ce_take),
        .ue_take     (ue_take),
        .panic_on_ue (panic_on_ue),
        .log_ce_en   (log_ce_en),
        .log_ue_en   (log_ue_en),
        .panic_req   (panic_req),
        .log_ce_req  (log_ce_req),
        .log_ue_req  (log_ue_req)
    );

    mes_sec_timer #(.CPS(CYCLES_PER_SEC), .SEC_W(SEC_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_strobe),
        .sec   (sec_q)
    );

    mes_sat_counter #(.CNT_W(CNT_W)) u_ce_tot (
        .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(glob_inc.ce_tot), .q(ce_tot_q)
    );
    mes_sat_counter #(.CNT_W(CNT_W)) u_ue_tot (
        .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(glob_inc.ue_tot), .q(ue_tot_q)
    );
    mes_sat_counter #(.CNT_W(CNT_W)) u_ce_ni (
        .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(glob_inc.ce_ni), .q(ce_ni_q)
    );
    mes_sat_counter #(.CNT_W(CNT_W)) u_ue_ni (
        .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(glob_inc.ue_ni), .q(ue_ni_q)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        mes_sat_counter #(.CNT_W(CNT_W)) u_rce (
            .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(row_ce_inc[r]), .q(row_ce_q[r])
        );
        mes_sat_counter #(.CNT_W(CNT_W)) u_rue (
            .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .inc(row_ue_inc[r]), .q(row_ue_q[r])
        );
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            mes_sat_counter #(.CNT_W(CNT_W)) u_cce (
                .clk(clk), .rst_n(rst_n), .clr(clr_strobe),
                .inc(ch_ce_inc[r*NCH+c]), .q(ch_ce_q[r*NCH+c])
            );
            mes_sat_counter #(.CNT_W(CNT_W)) u_cue (
                .clk(clk), .rst_n(rst_n), .clr(clr_strobe),
                .inc(ch_ue_inc[r*NCH+c]), .q(ch_ue_q[r*NCH+c])
            );
        end
    end

    // Read decode: block 0 is global, block r+1 is row r.
    always_comb begin
        rd_mux = '0;
        if (rd_addr[AW-1:SH] == '0) begin
            case (rd_addr[SH-1:0])
                SH'(FLD_CE_TOT): rd_mux = RD_W'(ce_tot_q);
                SH'(FLD_UE_TOT): rd_mux = RD_W'(ue_tot_q);
                SH'(FLD_CE_NI):  rd_mux = RD_W'(ce_ni_q);
                SH'(FLD_UE_NI):  rd_mux = RD_W'(ue_ni_q);
                SH'(FLD_SEC):    rd_mux = RD_W'(sec_q);
                default:         rd_mux = '0;
            endcase
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (rd_addr[AW-1:SH] == RXW'(r + 1)) begin
                    if (rd_addr[SH-1:0] == SH'(0)) rd_mux = RD_W'(row_ce_q[r]);
                    if (rd_addr[SH-1:0] == SH'(1)) rd_mux = RD_W'(row_ue_q[r]);
                    for (int c = 0; c < NCH; c++) begin
                        if (rd_addr[SH-1:0] == SH'(2 + 2 * c)) rd_mux = RD_W'(ch_ce_q[r*NCH+c]);
                        if (rd_addr[SH-1:0] == SH'(3 + 2 * c)) rd_mux = RD_W'(ch_ue_q[r*NCH+c]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/mes_stats_chk.sv
module mes_stats_chk #(
    parameter int CNT_W = 32,
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_strobe,
    input logic             ev_valid,
    input logic             ev_is_ue,
    input logic             panic_on_ue,
    input logic             log_ce_en,
    input logic             log_ue_en,
    input logic [CNT_W-1:0] ce_tot,
    input logic [CNT_W-1:0] ue_tot,
    input logic [CNT_W-1:0] ue_ni,
    input logic [SEC_W-1:0] sec,
    input logic             panic_req,
    input logic             log_ce_req,
    input logic             log_ue_req
);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> (ce_tot == '0 && ue_tot == '0 && ue_ni == '0 && sec == '0 && !panic_req));

    assert_ce_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_is_ue && !clr_strobe && ce_tot != {CNT_W{1'b1}})
        |=> (ce_tot == $past(ce_tot) + CNT_W'(1)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_strobe |=> (ce_tot >= $past(ce_tot) && ue_tot >= $past(ue_tot)));

    assert_panic_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_is_ue && panic_on_ue && !clr_strobe)
        |=> (panic_req && ue_tot == $past(ue_tot) && ue_ni == $past(ue_ni)));

    assert_log_ce_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_ce_req |-> ($past(log_ce_en) && $past(ev_valid) && !$past(ev_is_ue) && !$past(clr_strobe)));

    assert_log_ue_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_ue_req |-> ($past(log_ue_en) && $past(ev_valid) && $past(ev_is_ue) && !$past(clr_strobe)));

    assert_sec_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_strobe |=> (sec >= $past(sec)));

endmodule

bind mes_stats_top mes_stats_chk #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_strobe  (clr_strobe),
    .ev_valid    (ev_valid),
    .ev_is_ue    (ev_is_ue),
    .panic_on_ue (panic_on_ue),
    .log_ce_en   (log_ce_en),
    .log_ue_en   (log_ue_en),
    .ce_tot      (ce_tot_q),
    .ue_tot      (ue_tot_q),
    .ue_ni       (ue_ni_q),
    .sec         (sec_q),
    .panic_req   (panic_req),
    .log_ce_req  (log_ce_req),
    .log_ue_req  (log_ue_req)
);

// File: tb/sim_mes_stats_top.sv
`timescale 1ns/1ps
module sim_mes_stats_top;

    localparam int SATV = 15;   // CNT_W = 4
    localparam int NVEC = 12;

    // Vector: {log_en, is_ue, loc_valid, row[3:0], chan}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_0_1_0000_0, 8'b1_1_1_0011_1, 8'b0_0_1_0101_1, 8'b0_1_1_0111_0,
        8'b1_0_0_0010_0, 8'b0_1_0_0001_1, 8'b1_0_1_1001_0, 8'b1_1_1_1111_1,
        8'b1_0_1_0011_1, 8'b0_0_1_0011_0, 8'b1_1_1_0000_1, 8'b0_1_1_0101_1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_strobe = 1'b0;
    logic        panic_on_ue = 1'b0;
    logic        log_ce_en = 1'b0;
    logic        log_ue_en = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_is_ue = 1'b0;
    logic        ev_loc_valid = 1'b0;
    logic [3:0]  ev_row = '0;
    logic [0:0]  ev_chan = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        panic_req;
    logic        log_ce_req;
    logic        log_ue_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_ce_tot, m_ue_tot, m_ce_ni, m_ue_ni;
    int m_row_ce [8];
    int m_row_ue [8];
    int m_ch_ce  [8][2];
    int m_ch_ue  [8][2];

    always #5 clk = ~clk;

    mes_stats_top #(
        .ROWS(8), .NCH(2), .CNT_W(4), .SEC_W(3), .RD_W(32), .CYCLES_PER_SEC(10)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .clr_strobe(clr_strobe), .panic_on_ue(panic_on_ue),
        .log_ce_en(log_ce_en), .log_ue_en(log_ue_en), .ev_valid(ev_valid),
        .ev_is_ue(ev_is_ue), .ev_loc_valid(ev_loc_valid), .ev_row(ev_row),
        .ev_chan(ev_chan), .rd_addr(rd_addr), .rd_data(rd_data),
        .panic_req(panic_req), .log_ce_req(log_ce_req), .log_ue_req(log_ue_req)
    );

    function automatic int sat_inc(input int v);
        return (v < SATV) ? v + 1 : SATV;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_zero();
        m_ce_tot = 0; m_ue_tot = 0; m_ce_ni = 0; m_ue_ni = 0;
        for (int r = 0; r < 8; r++) begin
            m_row_ce[r] = 0; m_row_ue[r] = 0;
            for (int c = 0; c < 2; c++) begin
                m_ch_ce[r][c] = 0; m_ch_ue[r][c] = 0;
            end
        end
    endtask

    function automatic int exp_reg(input int a);
        int blk, fld;
        blk = a / 8;
        fld = a % 8;
        if (blk == 0) begin
            case (fld)
                0: return m_ce_tot;
                1: return m_ue_tot;
                2: return m_ce_ni;
                3: return m_ue_ni;
                default: return 0;   // seconds checked separately
            endcase
        end
        case (fld)
            0: return m_row_ce[blk-1];
            1: return m_row_ue[blk-1];
            2: return m_ch_ce[blk-1][0];
            3: return m_ch_ue[blk-1][0];
            4: return m_ch_ce[blk-1][1];
            5: return m_ch_ue[blk-1][1];
            default: return 0;
        endcase
    endfunction

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 7'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic dump(input string tag);
        int v;
        for (int a = 0; a < 72; a++) begin
            if (a != 4) begin
                rd(a, v);
                check(tag, $sformatf("addr %0d", a), v, exp_reg(a));
            end
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        model_zero();
    endtask

    // Apply one event; optionally with clear in the same cycle.
    task automatic do_event(input bit logen, input bit ue, input bit loc,
                            input int row, input int ch, input bit with_clr);
        bit located;
        @(negedge clk);
        log_ce_en = logen; log_ue_en = logen;
        ev_valid = 1'b1; ev_is_ue = ue; ev_loc_valid = loc;
        ev_row = 4'(row); ev_chan = 1'(ch);
        clr_strobe = with_clr;
        @(negedge clk);
        ev_valid = 1'b0; clr_strobe = 1'b0;
        check("R7", "log_ce_req", int'(log_ce_req), int'(!with_clr && logen && !ue));
        check("R7", "log_ue_req", int'(log_ue_req), int'(!with_clr && logen && ue));
        if (with_clr) begin
            model_zero();
        end else if (!(ue && panic_on_ue)) begin
            located = loc && (row < 8);
            if (ue) begin
                m_ue_tot = sat_inc(m_ue_tot);
                if (located) begin
                    m_row_ue[row] = sat_inc(m_row_ue[row]);
                    m_ch_ue[row][ch] = sat_inc(m_ch_ue[row][ch]);
                end else m_ue_ni = sat_inc(m_ue_ni);
            end else begin
                m_ce_tot = sat_inc(m_ce_tot);
                if (located) begin
                    m_row_ce[row] = sat_inc(m_row_ce[row]);
                    m_ch_ce[row][ch] = sat_inc(m_ch_ce[row][ch]);
                end else m_ce_ni = sat_inc(m_ce_ni);
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        bit ue, loc, logen;
        int row, ch;
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "panic_req", int'(panic_req), 0);
        check("R1", "log_ce_req", int'(log_ce_req), 0);
        check("R1", "log_ue_req", int'(log_ue_req), 0);
        dump("R1");

        // Vector walk: R2, R3, R4, R7
        for (int i = 0; i < NVEC; i++) begin
            logen = VEC[i][7]; ue = VEC[i][6]; loc = VEC[i][5];
            row = int'(VEC[i][4:1]); ch = int'(VEC[i][0]);
            do_event(logen, ue, loc, row, ch, 1'b0);
            rd(ue ? 1 : 0, v);
            check("R2", $sformatf("vec %0d total", i), v, ue ? m_ue_tot : m_ce_tot);
            if (loc && row < 8) begin
                rd(8 + 8*row + (ue ? 1 : 0), v);
                check("R3", $sformatf("vec %0d row", i), v, ue ? m_row_ue[row] : m_row_ce[row]);
                rd(8 + 8*row + 2 + 2*ch + (ue ? 1 : 0), v);
                check("R3", $sformatf("vec %0d chan", i), v, ue ? m_ch_ue[row][ch] : m_ch_ce[row][ch]);
            end else begin
                rd(ue ? 3 : 2, v);
                check("R4", $sformatf("vec %0d noinfo", i), v, ue ? m_ue_ni : m_ce_ni);
            end
        end
        dump("R10");

        // R8: saturation
        for (int k = 0; k < 20; k++) do_event(1'b0, 1'b0, 1'b1, 2, 1, 1'b0);
        rd(8 + 16 + 4, v);
        check("R8", "row2 ch1 CE saturated", v, SATV);
        rd(0, v);
        check("R8", "CE total saturated", v, SATV);
        dump("R8");

        // R5: clear with a simultaneous event
        do_event(1'b1, 1'b0, 1'b1, 1, 0, 1'b1);
        dump("R5");

        // R9: seconds timer
        do_clear();
        repeat (14) @(negedge clk);
        rd(4, v);
        check("R9", "seconds after 15 cycles", v, 1);
        repeat (10) @(negedge clk);
        rd(4, v);
        check("R9", "seconds after 26 cycles", v, 2);
        repeat (100) @(negedge clk);
        rd(4, v);
        check("R9", "seconds saturated", v, 7);
        do_clear();
        rd(4, v);
        check("R5", "seconds restarted", v, 0);

        // R6: panic on UE
        panic_on_ue = 1'b1;
        do_event(1'b1, 1'b1, 1'b1, 1, 0, 1'b0);
        check("R6", "panic_req raised", int'(panic_req), 1);
        do_event(1'b0, 1'b0, 1'b1, 1, 0, 1'b0);
        do_event(1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
        check("R6", "panic_req held", int'(panic_req), 1);
        rd(1, v);  check("R6", "UE total frozen", v, 0);
        rd(3, v);  check("R6", "UE noinfo frozen", v, 0);
        rd(17, v); check("R6", "row1 UE frozen", v, 0);
        rd(19, v); check("R6", "row1 ch0 UE frozen", v, 0);
        rd(16, v); check("R6", "row1 CE still counts", v, 1);
        do_clear();
        check("R5", "panic released by clear", int'(panic_req), 0);
        panic_on_ue = 1'b0;
        dump("R5");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule